// File: doc/BRIEF.md
# Stream Packet Byte-Length Meter

This block sits on a valid/ready streaming link as a pure observer. Payload, lane qualifiers, valid, ready and the end-of-packet flag pass straight through with no register in the path, so the link keeps its full rate and its back-pressure. The upstream ready is the downstream ready. The block never stalls the stream and never adds a beat to it.

For every lane of a transferred beat, the block decides what kind of byte the lane holds:

- **Data byte:** kept and strobed.
- **Position byte:** kept but not strobed. It fills a lane but carries no payload.
- **Null byte:** not kept. It is ignored.

A beat counts only in a cycle where valid and ready are both high. The block keeps running totals of data bytes, position bytes and beats. On the beat that carries the end-of-packet flag, it adds that beat's own share to the totals and presents the finished figures on a result port, with a one-cycle strobe, in the following cycle. The running totals restart at once, so a packet that begins on the very next beat is counted from zero.

A parameter removes the strobe qualifier. In that case every kept lane is a data byte and the position count stays zero. The result port has no ready. A consumer must capture the figures in the strobe cycle, and they stay on the port until the next packet closes.

Top module: `pkt_len_meter`

## Requirements
- R1: `dn_data`, `dn_keep`, `dn_strb`, `dn_valid` and `dn_last` equal the matching upstream inputs in the same cycle. `up_ready` equals `dn_ready` in the same cycle.
- R2: A lane whose keep bit is 1 and whose strobe bit is 1 adds one to the packet's data-byte count.
- R3: A lane whose keep bit is 1 and whose strobe bit is 0 adds one to the position-byte count and nothing to the data-byte count.
- R4: A lane whose keep bit is 0 adds to no count, whatever its strobe bit.
- R5: With `USE_STRB` = 0, every kept lane is a data byte and `res_pos_bytes` reports 0.
- R6: Only beats with `up_valid` = 1 and `dn_ready` = 1 are counted. A stalled beat adds nothing.
- R7: `res_valid` is high for exactly the one cycle after each transfer whose `up_last` is 1, and is low in every other cycle.
- R8: The reported counts include the end-of-packet beat itself. A packet that starts on the beat right after it is counted from zero, with no beat lost.
- R9: While `rst_n` is low at a clock edge, all totals clear and `res_valid` goes low. All result counts read 0 after reset.
- R10: On a 4-byte bus, a 10-byte payload sent as two full beats and a last beat with keep = 4'b0011 reports 10 data bytes, 0 position bytes and 3 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_data | input | DATA_W | Upstream payload |
| up_keep | input | DATA_W/8 | Upstream keep bits, one per byte lane |
| up_strb | input | DATA_W/8 | Upstream strobe bits, one per byte lane (ignored when USE_STRB = 0) |
| up_valid | input | 1 | Upstream beat valid |
| up_last | input | 1 | Upstream end-of-packet flag |
| up_ready | output | 1 | Ready returned upstream (copy of dn_ready) |
| dn_data | output | DATA_W | Downstream payload |
| dn_keep | output | DATA_W/8 | Downstream keep bits |
| dn_strb | output | DATA_W/8 | Downstream strobe bits |
| dn_valid | output | 1 | Downstream beat valid |
| dn_last | output | 1 | Downstream end-of-packet flag |
| dn_ready | input | 1 | Ready from the downstream consumer |
| res_valid | output | 1 | One-cycle strobe marking a finished packet result |
| res_data_bytes | output | CNT_W | Data bytes in the finished packet |
| res_pos_bytes | output | CNT_W | Position bytes in the finished packet |
| res_beats | output | CNT_W | Beats in the finished packet |

## Verification
A running total that fails to clear, or clears one beat late, shows up in the very next result strobe. The next packet's figures come out too large by the stray amount, or a short beat goes missing. Back-to-back single-beat packets expose this within two cycles. A lane sorted into the wrong class shows as a swap between the data and position counts in the next strobe. A counted stall beat shows as an inflated beat count. A strobe that is misplaced or too long is caught cycle by cycle against the handshakes the bench itself drove.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int PLM_CNT_W = 16;

  function automatic int unsigned plm_sum_w(input int unsigned lanes);
    return $clog2(lanes + 1);
  endfunction
endpackage

// File: rtl/plm_lane_sort.sv
module plm_lane_sort #(
  parameter int LANES    = 4,
  parameter bit USE_STRB = 1'b1,
  parameter int SUM_W    = 3
) (
  input  logic [LANES-1:0] keep,
  input  logic [LANES-1:0] strb,
  output logic [SUM_W-1:0] n_data,
  output logic [SUM_W-1:0] n_pos
);
  logic [LANES-1:0] is_data;
  logic [LANES-1:0] is_pos;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (USE_STRB) begin : g_strb
        assign is_data[g] = keep[g] & strb[g];
        assign is_pos[g]  = keep[g] & ~strb[g];
      end else begin : g_nostrb
        assign is_data[g] = keep[g];
        assign is_pos[g]  = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    n_data = '0;
    n_pos  = '0;
    for (int i = 0; i < LANES; i++) begin
      n_data = n_data + SUM_W'(is_data[i]);
      n_pos  = n_pos + SUM_W'(is_pos[i]);
    end
  end
endmodule

// File: rtl/plm_tally.sv
module plm_tally #(
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             close,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] result
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] sum;

  assign sum = run_q + {{(CNT_W-INC_W){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      result <= '0;
    end else if (step) begin
      if (close) begin
        run_q  <= '0;
        result <= sum;
      end else begin
        run_q <= sum;
      end
    end
  end
endmodule

// File: rtl/pkt_len_meter.sv
module pkt_len_meter
  import plm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = PLM_CNT_W,
  parameter bit USE_STRB = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   up_data,
  input  logic [DATA_W/8-1:0] up_keep,
  input  logic [DATA_W/8-1:0] up_strb,
  input  logic                up_valid,
  input  logic                up_last,
  output logic                up_ready,
  output logic [DATA_W-1:0]   dn_data,
  output logic [DATA_W/8-1:0] dn_keep,
  output logic [DATA_W/8-1:0] dn_strb,
  output logic                dn_valid,
  output logic                dn_last,
  input  logic                dn_ready,
  output logic                res_valid,
  output logic [CNT_W-1:0]    res_data_bytes,
  output logic [CNT_W-1:0]    res_pos_bytes,
  output logic [CNT_W-1:0]    res_beats
);
  localparam int LANES = DATA_W / 8;
  localparam int SUM_W = plm_sum_w(LANES);

  // Straight-through link, no register in the path
  assign dn_data  = up_data;
  assign dn_keep  = up_keep;
  assign dn_strb  = up_strb;
  assign dn_valid = up_valid;
  assign dn_last  = up_last;
  assign up_ready = dn_ready;

  logic             xfer;
  logic [SUM_W-1:0] n_data;
  logic [SUM_W-1:0] n_pos;

  assign xfer = up_valid & dn_ready;

  plm_lane_sort #(.LANES(LANES), .USE_STRB(USE_STRB), .SUM_W(SUM_W)) sort_i (
    .keep(up_keep), .strb(up_strb), .n_data(n_data), .n_pos(n_pos)
  );

  plm_tally #(.CNT_W(CNT_W), .INC_W(SUM_W)) data_tally_i (
    .clk(clk), .rst_n(rst_n), .step(xfer), .close(up_last),
    .inc(n_data), .result(res_data_bytes)
  );

  plm_tally #(.CNT_W(CNT_W), .INC_W(SUM_W)) pos_tally_i (
    .clk(clk), .rst_n(rst_n), .step(xfer), .close(up_last),
    .inc(n_pos), .result(res_pos_bytes)
  );

  plm_tally #(.CNT_W(CNT_W), .INC_W(1)) beat_tally_i (
    .clk(clk), .rst_n(rst_n), .step(xfer), .close(up_last),
    .inc(1'b1), .result(res_beats)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= xfer & up_last;
  end
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int LANES    = 4,
  parameter int CNT_W    = 16,
  parameter bit USE_STRB = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic             up_last,
  input logic             dn_ready,
  input logic             res_valid,
  input logic [CNT_W-1:0] res_data_bytes,
  input logic [CNT_W-1:0] res_pos_bytes,
  input logic [CNT_W-1:0] res_beats
);
  // R7
  res_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(up_valid && dn_ready && up_last));

  // R8
  beats_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_beats != '0));

  // R2
  lanes_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((32'(res_data_bytes) + 32'(res_pos_bytes)) <= 32'(res_beats) * LANES));

  // R5
  no_pos_without_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !USE_STRB) |-> (res_pos_bytes == '0));
endmodule

bind pkt_len_meter plm_checker #(.LANES(DATA_W/8), .CNT_W(CNT_W), .USE_STRB(USE_STRB)) chk_i (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_last(up_last), .dn_ready(dn_ready),
  .res_valid(res_valid), .res_data_bytes(res_data_bytes),
  .res_pos_bytes(res_pos_bytes), .res_beats(res_beats)
);

// File: tb/pkt_len_meter_tb_top.sv
module pkt_len_meter_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] up_data = '0;
  logic [3:0]  up_keep = '0, up_strb = '0;
  logic        up_valid = 1'b0, up_last = 1'b0, dn_ready = 1'b0;
  logic        up_ready, dn_valid, dn_last, res_valid;
  logic [31:0] dn_data;
  logic [3:0]  dn_keep, dn_strb;
  logic [15:0] res_d, res_p, res_b;
  logic        ns_up_ready, ns_dn_valid, ns_dn_last, ns_res_valid;
  logic [31:0] ns_dn_data;
  logic [3:0]  ns_dn_keep, ns_dn_strb;
  logic [15:0] ns_res_d, ns_res_p, ns_res_b;

  pkt_len_meter #(.DATA_W(32), .CNT_W(16), .USE_STRB(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_keep(up_keep), .up_strb(up_strb),
    .up_valid(up_valid), .up_last(up_last), .up_ready(up_ready), .dn_data(dn_data),
    .dn_keep(dn_keep), .dn_strb(dn_strb), .dn_valid(dn_valid), .dn_last(dn_last),
    .dn_ready(dn_ready), .res_valid(res_valid), .res_data_bytes(res_d),
    .res_pos_bytes(res_p), .res_beats(res_b));

  pkt_len_meter #(.DATA_W(32), .CNT_W(16), .USE_STRB(1'b0)) dut_ns_i (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_keep(up_keep), .up_strb(up_strb),
    .up_valid(up_valid), .up_last(up_last), .up_ready(ns_up_ready), .dn_data(ns_dn_data),
    .dn_keep(ns_dn_keep), .dn_strb(ns_dn_strb), .dn_valid(ns_dn_valid), .dn_last(ns_dn_last),
    .dn_ready(dn_ready), .res_valid(ns_res_valid), .res_data_bytes(ns_res_d),
    .res_pos_bytes(ns_res_p), .res_beats(ns_res_b));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int acc_d = 0, acc_p = 0, acc_b = 0, acc_k = 0;
  bit exp_rv = 1'b0;
  int e_d = 0, e_p = 0, e_b = 0, e_k = 0;

  function automatic int ones(input logic [3:0] v);
    int c = 0;
    for (int i = 0; i < 4; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_res();
    // R7 strobe timing on both instances
    chk(res_valid == exp_rv, "R7 res_valid", res_valid, exp_rv);
    chk(ns_res_valid == exp_rv, "R7 ns res_valid", ns_res_valid, exp_rv);
    if (exp_rv) begin
      // R2 R3 R4 R6 R8 counts with strobe qualifier
      chk(res_d == 16'(e_d), "R2/R4/R8 data bytes", res_d, e_d);
      chk(res_p == 16'(e_p), "R3 position bytes", res_p, e_p);
      chk(res_b == 16'(e_b), "R6/R8 beats", res_b, e_b);
      // R5 no strobe qualifier: kept lanes are data
      chk(ns_res_d == 16'(e_k), "R5 data bytes", ns_res_d, e_k);
      chk(ns_res_p == 16'd0, "R5 position bytes", ns_res_p, 0);
      chk(ns_res_b == 16'(e_b), "R5 beats", ns_res_b, e_b);
    end
  endtask

  task automatic step(input bit v, input bit r, input bit l,
                      input logic [3:0] k, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    check_res();
    up_valid = v; dn_ready = r; up_last = l; up_keep = k; up_strb = s; up_data = d;
    #1;
    // R1 pass-through
    chk(dn_data == up_data && dn_keep == up_keep && dn_strb == up_strb &&
        dn_valid == up_valid && dn_last == up_last, "R1 forward", dn_data, up_data);
    chk(up_ready == dn_ready && ns_up_ready == dn_ready, "R1 ready", up_ready, dn_ready);
    exp_rv = 1'b0;
    if (v && r) begin
      acc_d += ones(k & s); acc_p += ones(k & ~s); acc_k += ones(k); acc_b += 1;
      if (l) begin
        exp_rv = 1'b1;
        e_d = acc_d; e_p = acc_p; e_b = acc_b; e_k = acc_k;
        acc_d = 0; acc_p = 0; acc_b = 0; acc_k = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(res_valid == 1'b0 && res_d == 0 && res_p == 0 && res_b == 0, "R9 reset", res_d, 0);
    rst_n = 1'b1;
    // R10 ten bytes on a 4-byte bus
    step(1, 1, 0, 4'hF, 4'hF, 32'h11);
    step(1, 1, 0, 4'hF, 4'hF, 32'h22);
    step(1, 1, 1, 4'h3, 4'h3, 32'h33);
    step(0, 1, 0, 4'h0, 4'h0, 32'h0);
    chk(res_d == 16'd10 && res_b == 16'd3 && res_p == 16'd0, "R10 ten-byte packet", res_d, 10);
    // R8 back-to-back single-beat packets
    step(1, 1, 1, 4'hF, 4'h5, 32'h1);
    step(1, 1, 1, 4'h1, 4'h1, 32'h2);
    step(1, 1, 1, 4'hE, 4'h0, 32'h3);
    // R6 stalls are not counted; R4 strobe on unkept lanes ignored
    step(1, 0, 0, 4'hF, 4'hF, 32'h4);
    step(1, 0, 0, 4'hF, 4'hF, 32'h4);
    step(1, 1, 0, 4'hF, 4'hF, 32'h4);
    step(0, 1, 1, 4'hF, 4'hF, 32'h5);
    step(1, 1, 1, 4'h1, 4'hF, 32'h6);
    step(0, 0, 0, 4'h0, 4'h0, 32'h0);
    // R9 mid-packet reset then fresh count
    step(1, 1, 0, 4'hF, 4'hF, 32'h7);
    @(negedge clk); check_res(); rst_n = 1'b0; up_valid = 1'b0; exp_rv = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(res_valid == 1'b0 && res_b == 0, "R9 mid reset", res_b, 0);
    acc_d = 0; acc_p = 0; acc_b = 0; acc_k = 0;
    step(1, 1, 1, 4'h3, 4'h1, 32'h8);
    // Random traffic
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 5) == 0,
           4'($urandom), 4'($urandom), $urandom);
    end
    step(0, 1, 0, 4'h0, 4'h0, 32'h0);
    step(0, 1, 0, 4'h0, 4'h0, 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule